// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address presented to a synchronous SRAM array during a four-beat burst. When a burst opens, the external address is captured whole. Each later advance request moves the burst to its next beat. Only the two least significant address bits change from beat to beat, and the bits above them stay put.

The sequence of the two low bits follows one of two orders. Interleaved order flips bits of the start value with an XOR against the beat index. Linear order counts upward and wraps within the group of four. The order is taken from a select input at the moment the burst is loaded. A cycle with no advance request suspends the burst, and the address holds. The array itself, chip-select decoding and the data path belong to other blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the address and the beat position clear to zero, so `addr_o` reads 0 after that edge.
- R2: With `load_i` high at a rising edge, `addr_o` equals the `ext_addr_i` value sampled at that edge from the following cycle on. That value is beat 0 of the new burst.
- R3: A burst loaded with `order_i` = 1 (interleaved) presents, at beat k, low two bits equal to the start low bits XOR k. Start 01 gives 01, 00, 11, 10.
- R4: A burst loaded with `order_i` = 0 (linear) presents, at beat k, low two bits equal to (start + k) mod 4. Start 11 gives 11, 00, 01, 10.
- R5: With `load_i` low, `adv_i` high at a rising edge moves to the next beat, and `adv_i` low holds `addr_o` unchanged (suspend).
- R6: Bits above the low two never change except on a load. An advance from the fourth beat returns to the start address of the same group of four, with no carry upward.
- R7: When `load_i` and `adv_i` are both high at the same edge, the load wins: `addr_o` becomes the new external address at beat 0.
- R8: `order_i` is sampled only on a load. Changing it during a burst has no effect on the order of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a burst from `ext_addr_i` |
| adv_i | input | 1 | Step to the next beat when no load is present |
| order_i | input | 1 | Beat order: 1 interleaved, 0 linear |
| ext_addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current internal burst address |

## Verification
The assertions expect every input to be driven to a known level at each rising edge once reset is released. They also expect `rst` to be asserted for at least one edge at start-up. They place no limit on how loads, advances and suspends are mixed, so a load in the middle of a burst or an advance after the fourth beat is legal. The bench changes inputs only well away from the active edge and holds reset for several cycles before any scenario. The scenarios mix loads, advances, suspends and order changes in both legal orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } beat_order_e;

  // Low address bits presented at a given beat of the burst.
  function automatic logic [BEAT_W-1:0] beat_low_bits(
    input logic [BEAT_W-1:0] start_bits,
    input logic [BEAT_W-1:0] beat_idx,
    input beat_order_e       order
  );
    logic [BEAT_W-1:0] res;
    if (order == ORDER_XOR) res = start_bits ^ beat_idx;
    else                    res = start_bits + beat_idx;
    return res;
  endfunction

endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst)         beat_q <= '0;
    else if (clr_i)  beat_q <= '0;
    else if (step_i) beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;

  // R5: a step without clear moves the counter by one position
  assert_beat_step_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clr_i) |=> (beat_q == $past(beat_q) + 1'b1));

  // R2: a clear returns the counter to beat 0
  assert_beat_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (beat_q == '0));

endmodule

// File: rtl/bsq_low_gen.sv
module bsq_low_gen
  import burst_seq_pkg::*;
(
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  beat_order_e       order_i,
  output logic [BEAT_W-1:0] low_o
);

  always_comb low_o = beat_low_bits(start_i, beat_i, order_i);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] start_q;
  beat_order_e       order_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low_bits;

  // named events for the checks below
  logic burst_load;
  logic burst_step;
  logic burst_hold;

  assign burst_load = load_i;
  assign burst_step = !load_i && adv_i;
  assign burst_hold = !load_i && !adv_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      start_q <= '0;
      order_q <= ORDER_XOR;
    end else if (burst_load) begin
      hi_q    <= ext_addr_i[ADDR_W-1:BEAT_W];
      start_q <= ext_addr_i[BEAT_W-1:0];
      order_q <= beat_order_e'(order_i);
    end
  end

  bsq_beat_ctr u_beat (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (burst_load),
    .step_i (burst_step),
    .beat_o (beat)
  );

  bsq_low_gen u_low (
    .start_i (start_q),
    .beat_i  (beat),
    .order_i (order_q),
    .low_o   (low_bits)
  );

  assign addr_o = {hi_q, low_bits};

  // R1: reset clears the presented address
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (addr_o == '0));

  // R2 and R7: a load (even with an advance) presents the external address
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(ext_addr_i)));

  // R5: a suspend keeps the address unchanged
  assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    burst_hold |=> $stable(addr_o));

  // R6: upper bits move only on a load
  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R5: an advance always changes the low bits
  assert_step_moves_R5: assert property (@(posedge clk) disable iff (rst)
    burst_step |=> (addr_o[BEAT_W-1:0] != $past(addr_o[BEAT_W-1:0])));

  // R3: in interleaved order the low bits differ from the start by the beat index
  assert_xor_order_R3: assert property (@(posedge clk) disable iff (rst)
    (order_q == ORDER_XOR) |-> ((addr_o[BEAT_W-1:0] ^ start_q) == beat));

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              order_i = 1'b1;
  logic [ADDR_W-1:0] ext_addr_i = '0;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_i(adv_i),
    .order_i(order_i), .ext_addr_i(ext_addr_i), .addr_o(addr_o)
  );

  function automatic logic [1:0] exp_xor(input logic [1:0] s, input int k);
    logic [1:0] kk = k[1:0];
    return {s[1] ^ kk[1], s[0] ^ kk[0]};
  endfunction

  function automatic logic [1:0] exp_lin(input logic [1:0] s, input int k);
    return 2'((int'(s) + k) % 4);
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_o !== exp) begin
      failures++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  // apply inputs, take one rising edge, settle off the edge
  task automatic cycle(input logic ld, input logic adv, input logic ord,
                       input logic [ADDR_W-1:0] a);
    load_i = ld; adv_i = adv; order_i = ord; ext_addr_i = a;
    @(posedge clk);
    #(CLK_PERIOD/4);
    load_i = 1'b0; adv_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) cycle(1'b0, 1'b0, 1'b1, '0);
    check("R1", '0);
    rst = 1'b0;
  endtask

  task automatic t_order(input logic ord, input logic [ADDR_W-1:0] a,
                         input string req);
    logic [1:0] s = a[1:0];
    cycle(1'b1, 1'b0, ord, a);
    check("R2", a);
    for (int k = 1; k < 8; k++) begin
      cycle(1'b0, 1'b1, ord, 18'h0);
      check(k >= 4 ? "R6" : req,
            {a[ADDR_W-1:2], ord ? exp_xor(s, k) : exp_lin(s, k)});
    end
  endtask

  task automatic t_suspend();
    logic [ADDR_W-1:0] a = 18'h2A5C1;
    cycle(1'b1, 1'b0, 1'b1, a);
    cycle(1'b0, 1'b1, 1'b1, 18'h3FFFF);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 1'b0, 1'b1, 18'h3FFFF);
      check("R5", {a[ADDR_W-1:2], exp_xor(a[1:0], 1)});
    end
    cycle(1'b0, 1'b1, 1'b1, 18'h0);
    check("R5", {a[ADDR_W-1:2], exp_xor(a[1:0], 2)});
  endtask

  task automatic t_priority();
    logic [ADDR_W-1:0] a = 18'h1FFF2;
    cycle(1'b1, 1'b0, 1'b0, 18'h00003);
    cycle(1'b0, 1'b1, 1'b0, 18'h0);
    cycle(1'b1, 1'b1, 1'b0, a);
    check("R7", a);
    cycle(1'b0, 1'b1, 1'b0, 18'h0);
    check("R7", {a[ADDR_W-1:2], exp_lin(a[1:0], 1)});
  endtask

  task automatic t_mode_latch();
    logic [ADDR_W-1:0] a = 18'h04441;
    cycle(1'b1, 1'b0, 1'b0, a);
    cycle(1'b0, 1'b1, 1'b1, 18'h0);
    check("R8", {a[ADDR_W-1:2], exp_lin(a[1:0], 1)});
    cycle(1'b0, 1'b1, 1'b1, 18'h0);
    check("R8", {a[ADDR_W-1:2], exp_lin(a[1:0], 2)});
    cycle(1'b1, 1'b0, 1'b1, a);
    cycle(1'b0, 1'b1, 1'b0, 18'h0);
    check("R8", {a[ADDR_W-1:2], exp_xor(a[1:0], 1)});
  endtask

  initial begin
    #(CLK_PERIOD/4);
    t_reset();
    t_order(1'b1, 18'h12341, "R3");
    t_order(1'b1, 18'h3FFFE, "R3");
    t_order(1'b0, 18'h12341, "R4");
    t_order(1'b0, 18'h3FFFF, "R4");
    t_suspend();
    t_priority();
    t_mode_latch();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule